// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block controls an in-order pipeline of four stages: fetch, decode with operand read, execute, and write-back. It keeps one valid bit for each stage. It enables the program counter and inserts bubbles. For each source operand in decode, it also chooses where the value comes from. The datapath, the ALU and the memories sit outside the block. The block only sees the register indices and the control flags from each stage.

Read-after-write dependencies are resolved by forwarding, never by stalling. A source that matches the destination of a valid, writing instruction in execute takes the execute result. Failing that, a match in write-back takes the write-back latch. If neither matches, the source reads the register file. Loads and stores may share one memory port with instruction fetch. Two configuration bits choose whether each kind of access holds the front of the pipeline for one cycle while it owns the port. A taken branch in execute discards the younger instructions, and fetch restarts from the new address.

The sequencer has two states. FLOW is normal issue. PORT_WAIT is the cycle in which a memory instruction in write-back owns the shared port. The block takes the transition FLOW→PORT_WAIT or PORT_WAIT→PORT_WAIT when the execute stage holds a valid load with the load-stall bit set, or a valid store with the store-stall bit set. Otherwise it takes FLOW→FLOW or PORT_WAIT→FLOW.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted (active low), all four stage valid bits are 0, `pc_en` is 1 and `bubble` is 0.
- R2: With no stalls and no branches, after the k-th clock edge following reset release, the fetch, decode, execute and write-back valid bits are set once k is at least 1, 2, 3 and 4 respectively. Six instructions therefore retire within nine cycles.
- R3: A source whose index equals `e_dst` while `vld_e` and `e_wen` are both 1 gets select code 1 (execute result).
- R4: A source that does not match execute, but whose index equals `w_dst` while `vld_w` and `w_wen` are both 1, gets select code 2 (write-back latch).
- R5: When execute and write-back both match a source, the select is 1: execute has priority.
- R6: With no qualified match, the select is 0 (register file). A stage with a cleared valid bit or a cleared write enable never forwards. Source i uses `fwd_sel[2i+1:2i]` and `d_src[RW*i +: RW]`.
- R7: When `cfg_ld_stall` is 1, a clock edge that finds a valid load in execute starts a stall cycle. In that cycle `bubble` is 1, `pc_en` is 0, and the fetch and decode valid bits keep their values. At the end of the cycle the execute valid bit becomes 0.
- R8: When `cfg_st_stall` is 1, a valid store in execute causes the same one-cycle stall as in R7.
- R9: When the matching configuration bit is 0, a load or store in execute causes no stall: `bubble` stays 0 and `pc_en` stays 1.
- R10: A clock edge with `e_br_taken` and `vld_e` both 1 clears the fetch, decode and execute valid bits and moves the branch into write-back. Fetch is valid again after the next edge. `e_br_taken` has no effect while `vld_e` is 0.
- R11: `pc_en` is 1 in every cycle except a stall cycle without a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ld_stall | input | 1 | Loads hold the front of the pipeline one cycle |
| cfg_st_stall | input | 1 | Stores hold the front of the pipeline one cycle |
| d_src | input | RW*NUM_SRC | Decode source register indices, packed |
| e_dst | input | RW | Execute destination register |
| e_wen | input | 1 | Execute instruction writes a register |
| e_load | input | 1 | Execute instruction is a load |
| e_store | input | 1 | Execute instruction is a store |
| e_br_taken | input | 1 | Execute instruction changes program flow |
| w_dst | input | RW | Write-back destination register |
| w_wen | input | 1 | Write-back instruction writes a register |
| fwd_sel | output | 2*NUM_SRC | Per-source select: 0 register file, 1 execute, 2 write-back |
| pc_en | output | 1 | Program counter may advance or load |
| vld_f | output | 1 | Fetch stage valid |
| vld_d | output | 1 | Decode stage valid |
| vld_e | output | 1 | Execute stage valid |
| vld_w | output | 1 | Write-back stage valid |
| bubble | output | 1 | An empty slot enters execute this cycle |

## Verification
The hardest case to reach is a stall cycle, because it only occurs one edge after a memory instruction was seen in execute. The stimulus first fills the pipeline. It then raises the load or store flag for exactly one cycle and drops it before the stall cycle is sampled. This lets the hold of fetch and decode and the empty slot entering execute be checked edge by edge. A flush is reached the same way. Afterwards, the same branch flag is raised again while execute is empty, to show that it is ignored.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EXE = 2'd1,
        SRC_WB  = 2'd2
    } fwd_src_e;

    typedef enum logic {
        ST_FLOW      = 1'b0,
        ST_PORT_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/hzd_fwd_select.sv
module hzd_fwd_select
    import hzd_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic [RW-1:0] src,
    input  logic          e_vld,
    input  logic          e_wen,
    input  logic [RW-1:0] e_dst,
    input  logic          w_vld,
    input  logic          w_wen,
    input  logic [RW-1:0] w_dst,
    output fwd_src_e      sel
);

    logic hit_exe;
    logic hit_wb;

    always_comb begin
        hit_exe = e_vld && e_wen && (e_dst == src);
        hit_wb  = w_vld && w_wen && (w_dst == src);
        // the younger result in execute wins over the write-back latch
        if (hit_exe)     sel = SRC_EXE;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end

endmodule

// File: rtl/hzd_seq.sv
module hzd_seq
    import hzd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req,
    input  logic br_taken,
    output logic pc_en,
    output logic bubble,
    output logic vld_f,
    output logic vld_d,
    output logic vld_e,
    output logic vld_w
);

    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       redirect;
    logic       hold_front;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_nxt;
    end

    // next state and outputs
    always_comb begin
        redirect   = br_taken && vld_e;
        state_nxt  = mem_req ? ST_PORT_WAIT : ST_FLOW;
        hold_front = 1'b0;
        bubble     = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                hold_front = 1'b0;
                bubble     = 1'b0;
            end
            ST_PORT_WAIT: begin
                hold_front = 1'b1;
                bubble     = 1'b1;
            end
            default: begin
                hold_front = 1'b0;
                bubble     = 1'b0;
            end
        endcase
        pc_en = !hold_front || redirect;
    end

    // stage valid bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_f <= 1'b0;
            vld_d <= 1'b0;
            vld_e <= 1'b0;
            vld_w <= 1'b0;
        end else if (redirect) begin
            vld_f <= 1'b0;
            vld_d <= 1'b0;
            vld_e <= 1'b0;
            vld_w <= vld_e;
        end else if (hold_front) begin
            vld_e <= 1'b0;
            vld_w <= vld_e;
        end else begin
            vld_f <= 1'b1;
            vld_d <= vld_f;
            vld_e <= vld_d;
            vld_w <= vld_e;
        end
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int RW      = 4,
    parameter int NUM_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_ld_stall,
    input  logic                    cfg_st_stall,
    input  logic [RW*NUM_SRC-1:0]   d_src,
    input  logic [RW-1:0]           e_dst,
    input  logic                    e_wen,
    input  logic                    e_load,
    input  logic                    e_store,
    input  logic                    e_br_taken,
    input  logic [RW-1:0]           w_dst,
    input  logic                    w_wen,
    output logic [2*NUM_SRC-1:0]    fwd_sel,
    output logic                    pc_en,
    output logic                    vld_f,
    output logic                    vld_d,
    output logic                    vld_e,
    output logic                    vld_w,
    output logic                    bubble
);

    localparam int SELW = $bits(fwd_src_e);

    logic mem_req;

    assign mem_req = vld_e && ((e_load && cfg_ld_stall) || (e_store && cfg_st_stall));

    hzd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_req  (mem_req),
        .br_taken (e_br_taken),
        .pc_en    (pc_en),
        .bubble   (bubble),
        .vld_f    (vld_f),
        .vld_d    (vld_d),
        .vld_e    (vld_e),
        .vld_w    (vld_w)
    );

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        fwd_src_e sel;
        hzd_fwd_select #(.RW(RW)) u_sel (
            .src   (d_src[RW*gi +: RW]),
            .e_vld (vld_e),
            .e_wen (e_wen),
            .e_dst (e_dst),
            .w_vld (vld_w),
            .w_wen (w_wen),
            .w_dst (w_dst),
            .sel   (sel)
        );
        assign fwd_sel[SELW*gi +: SELW] = sel;
    end

endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
    parameter int RW      = 4,
    parameter int NUM_SRC = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_ld_stall,
    input logic                  cfg_st_stall,
    input logic [RW*NUM_SRC-1:0] d_src,
    input logic [RW-1:0]         e_dst,
    input logic                  e_wen,
    input logic                  e_load,
    input logic                  e_store,
    input logic                  e_br_taken,
    input logic [2*NUM_SRC-1:0]  fwd_sel,
    input logic                  pc_en,
    input logic                  vld_f,
    input logic                  vld_d,
    input logic                  vld_e,
    input logic                  vld_w,
    input logic                  bubble
);

    AST_FWD_EXE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_e && e_wen && e_dst == d_src[RW-1:0]) |-> fwd_sel[1:0] == 2'd1); // R5

    AST_LOAD_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_e && e_load && cfg_ld_stall) |=> bubble); // R7

    AST_STORE_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_e && e_store && cfg_st_stall) |=> bubble); // R8

    AST_STALL_HOLDS_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble && !(e_br_taken && vld_e)) |=> (vld_f == $past(vld_f) && vld_d == $past(vld_d) && !vld_e)); // R7

    AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble && !(vld_e && ((e_load && cfg_ld_stall) || (e_store && cfg_st_stall)))) |=> !bubble); // R7

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (e_br_taken && vld_e) |=> (!vld_f && !vld_d && !vld_e && vld_w)); // R10

    AST_PC_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_en) |=> (vld_f == $past(vld_f))); // R11

endmodule

bind pipe_hazard_ctrl hzd_checker #(.RW(RW), .NUM_SRC(NUM_SRC)) u_hzd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ld_stall (cfg_ld_stall),
    .cfg_st_stall (cfg_st_stall),
    .d_src        (d_src),
    .e_dst        (e_dst),
    .e_wen        (e_wen),
    .e_load       (e_load),
    .e_store      (e_store),
    .e_br_taken   (e_br_taken),
    .fwd_sel      (fwd_sel),
    .pc_en        (pc_en),
    .vld_f        (vld_f),
    .vld_d        (vld_d),
    .vld_e        (vld_e),
    .vld_w        (vld_w),
    .bubble       (bubble)
);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;

    localparam int RW = 4;
    localparam int NS = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_ld_stall = 1'b0;
    logic            cfg_st_stall = 1'b0;
    logic [RW*NS-1:0] d_src = '0;
    logic [RW-1:0]   e_dst = '0;
    logic            e_wen = 1'b0;
    logic            e_load = 1'b0;
    logic            e_store = 1'b0;
    logic            e_br_taken = 1'b0;
    logic [RW-1:0]   w_dst = '0;
    logic            w_wen = 1'b0;
    logic [2*NS-1:0] fwd_sel;
    logic            pc_en, vld_f, vld_d, vld_e, vld_w, bubble;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pipe_hazard_ctrl #(.RW(RW), .NUM_SRC(NS)) i_pipe_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_ld_stall(cfg_ld_stall), .cfg_st_stall(cfg_st_stall),
        .d_src(d_src), .e_dst(e_dst), .e_wen(e_wen), .e_load(e_load), .e_store(e_store),
        .e_br_taken(e_br_taken), .w_dst(w_dst), .w_wen(w_wen), .fwd_sel(fwd_sel),
        .pc_en(pc_en), .vld_f(vld_f), .vld_d(vld_d), .vld_e(vld_e), .vld_w(vld_w),
        .bubble(bubble)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int vbits();
        return {vld_f, vld_d, vld_e, vld_w};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 valids in reset", vbits(), 0);
        check("R1 pc_en in reset", pc_en, 1);
        check("R1 bubble in reset", bubble, 0);
    endtask

    task automatic t_stream();
        int retired = 0;
        rst_n = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            step();
            check("R2 fetch valid", vld_f, 1);
            check("R2 decode valid", vld_d, int'(k >= 2));
            check("R2 execute valid", vld_e, int'(k >= 3));
            check("R2 writeback valid", vld_w, int'(k >= 4));
            check("R11 pc_en streaming", pc_en, 1);
            if (vld_w) retired++;
        end
        check("R2 six retired in nine cycles", retired, 6);
    endtask

    task automatic t_forward();
        d_src = {4'd3, 4'd5};
        e_wen = 1'b1; e_dst = 4'd5;
        w_wen = 1'b1; w_dst = 4'd3;
        #1;
        check("R3 src0 from execute", fwd_sel[1:0], 1);
        check("R4 src1 from writeback", fwd_sel[3:2], 2);
        w_dst = 4'd5; #1;
        check("R5 execute beats writeback", fwd_sel[1:0], 1);
        check("R6 src1 no match", fwd_sel[3:2], 0);
        e_wen = 1'b0; #1;
        check("R4 src0 writeback when execute not writing", fwd_sel[1:0], 2);
        w_wen = 1'b0; #1;
        check("R6 src0 register file", fwd_sel[1:0], 0);
        @(negedge clk);
    endtask

    task automatic t_mem_stall(input bit is_load);
        string rq;
        rq = is_load ? "R7" : "R8";
        cfg_ld_stall = is_load;
        cfg_st_stall = !is_load;
        e_load = is_load;
        e_store = !is_load;
        #1;
        check({rq, " no stall yet"}, bubble, 0);
        step();
        e_load = 1'b0; e_store = 1'b0;
        #1;
        check({rq, " bubble in stall"}, bubble, 1);
        check("R11 pc_en low in stall", pc_en, 0);
        check({rq, " fetch and decode held"}, {vld_f, vld_d}, 3);
        step();
        check({rq, " execute empty after stall"}, vld_e, 0);
        check({rq, " stall lasts one cycle"}, bubble, 0);
        check("R11 pc_en back", pc_en, 1);
        step();
        check({rq, " execute refilled"}, vld_e, 1);
        cfg_ld_stall = 1'b0; cfg_st_stall = 1'b0;
    endtask

    task automatic t_no_stall();
        cfg_ld_stall = 1'b0; cfg_st_stall = 1'b0;
        e_load = 1'b1;
        step();
        e_load = 1'b0;
        #1;
        check("R9 load without config", bubble, 0);
        check("R9 pc_en without config", pc_en, 1);
        cfg_ld_stall = 1'b1; e_store = 1'b1;
        step();
        e_store = 1'b0;
        #1;
        check("R9 store with only load config", bubble, 0);
        cfg_ld_stall = 1'b0;
        step();
    endtask

    task automatic t_flush();
        e_br_taken = 1'b1;
        step();
        e_br_taken = 1'b0;
        check("R10 flush clears front, branch retires", vbits(), 4'b0001);
        e_wen = 1'b1; e_dst = 4'd7; w_wen = 1'b1; w_dst = 4'd7; d_src = {4'd0, 4'd7};
        #1;
        check("R6 empty execute does not forward", fwd_sel[1:0], 2);
        e_wen = 1'b0; w_wen = 1'b0;
        step();
        check("R10 refetch after flush", vbits(), 4'b1000);
        step();
        check("R10 refill continues", vbits(), 4'b1100);
        e_br_taken = 1'b1;
        step();
        e_br_taken = 1'b0;
        check("R10 branch ignored while execute empty", vbits(), 4'b1110);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_forward();
        t_mem_stall(1'b1);
        t_mem_stall(1'b0);
        t_no_stall();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule